// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register Bank

This block is the register front end for a group of DMA channels. Software sees seven 32-bit word locations. Through them it sets each channel's transfer mode and direction, and enables each channel's interrupt. It also reads every channel's pending interrupt, error flag and 2-bit engine state. The data-moving engines sit behind the bank. Each engine gets its own mode and direction lines and a one-cycle start or disable strobe. Each engine returns a 2-bit state plus single-cycle done and error pulses.

Channels are arranged in groups of eight. Channels 0 to 7 share the low control word and the low status word. Channels 8 to 11 use a second control word and a second status word with the same per-slot layout. Their interrupt enables sit higher in the shared enable word. The bank can be built for 4, 8 or 12 channels. A single interrupt line tells the host that at least one enabled channel has work to report. Software acknowledges by writing the status value it read back to the same location.

Top module: `dmareg_bank`

## Requirements
- R1: Word index 0 (byte 0x00) is the low control word. Index 3 (0x0C) is the high control word and index 2 (0x08) is the enable word. Index 4 (0x10) is the low status word and index 6 (0x18) is the high status word. Indices 1, 5 and 7 read zero, and writes to them change no state and raise no strobe.
- R2: Channel c has a 4-bit control nibble at bits 4s+3..4s of its group's control word. The slot s is c for c<8 and c-8 otherwise. Nibble bits 1:0 hold the mode (0 off, 1 chained, 2 single). Bit 2 holds the direction, and bit 3 reads zero. The mode and direction are driven on `ch_mode[2c+1:2c]` and `ch_dir[c]`.
- R3: A written nibble whose mode bits are 3 leaves that channel's mode and direction unchanged and raises no strobe for it.
- R4: A control write raises `ch_start[c]` in the same cycle if the written mode is 1 or 2. It raises `ch_stop[c]` if the written mode is 0. Every channel of the written group whose mode is not 3 gets its strobe.
- R5: The interrupt enable of channel c is bit c of the enable word for c<8 and bit c+8 for c>=8. All other enable bits read zero.
- R6: In a status word, slot s shows pending at bit s, error at bit s+8, and the engine state at bits 17+2s..16+2s.
- R7: A `ch_done` or `ch_err` pulse sets the channel's pending bit on the next clock edge, and `ch_err` also sets its error bit. The error bit is never set while pending is clear.
- R8: Writing 1 to a pending bit clears pending and error. Writing 1 to an error bit clears only the error. Zero bits and state fields are unaffected by status writes.
- R9: A done or error pulse in the same cycle as a clear of that channel leaves pending set.
- R10: `irq` is high exactly when some channel has both pending and enable set. It follows a pulse on an enabled channel by one clock.
- R11: Bits belonging to channels beyond NUM_CH read zero, and writes to them are ignored. NUM_CH other than 4, 8 or 12 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_word | input | 3 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_word`, combinational |
| ch_mode | output | 2*NUM_CH | Per-channel transfer mode |
| ch_dir | output | NUM_CH | Per-channel direction |
| ch_start | output | NUM_CH | One-cycle start strobe per channel |
| ch_stop | output | NUM_CH | One-cycle disable strobe per channel |
| ch_state | input | 2*NUM_CH | Per-channel engine state |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel error pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The scoreboard reads every register location after each stimulus. A bit landing in the wrong slot, or a nibble overwritten by a keep code, shows up on `reg_rdata` in the cycle after the write. Strobes are combinational, so a wrong start or disable decision is visible in the same cycle as the control write. A pending or error flag that fails to set, fails to clear, or loses a same-cycle race against a clear changes both the status readback and `irq` one clock after the pulse or the write.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   localparam int REG_W     = 32;
   localparam int GROUP_SZ  = 8;
   localparam int NIB_W     = 4;
   localparam int ERR_BASE  = 8;
   localparam int ST_BASE   = 16;
   localparam int EN_HI_OFS = 8;

   localparam logic [2:0] W_CTL_LO = 3'd0;
   localparam logic [2:0] W_CTL_RS = 3'd1;
   localparam logic [2:0] W_ENABLE = 3'd2;
   localparam logic [2:0] W_CTL_HI = 3'd3;
   localparam logic [2:0] W_STS_LO = 3'd4;
   localparam logic [2:0] W_STS_RS = 3'd5;
   localparam logic [2:0] W_STS_HI = 3'd6;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_CHAIN  = 2'd1,
      MODE_SINGLE = 2'd2,
      MODE_KEEP   = 2'd3
   } xfer_mode_e;
endpackage

// File: rtl/dmareg_chan_ctl.sv
module dmareg_chan_ctl
   import dmareg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [3:0] wr_nib,
   output logic [1:0] mode,
   output logic       dir,
   output logic       start_stb,
   output logic       stop_stb
);
   logic take;

   assign take      = wr_hit && (wr_nib[1:0] != MODE_KEEP);
   assign start_stb = take && (wr_nib[1:0] != MODE_OFF);
   assign stop_stb  = take && (wr_nib[1:0] == MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_OFF;
         dir  <= 1'b0;
      end else if (take) begin
         mode <= wr_nib[1:0];
         dir  <= wr_nib[2];
      end
   end

   a_r3_keep_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_nib[1:0] == MODE_KEEP) |=> ($stable(mode) && $stable(dir)));

   a_r4_start_runs : assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |=> (mode != MODE_OFF));

   a_r4_stop_idles : assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> (mode == MODE_OFF));

   a_r4_one_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_stb, stop_stb}));
endmodule

// File: rtl/dmareg_chan_stat.sv
module dmareg_chan_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic err,
   input  logic st_wr,
   input  logic clr_pend,
   input  logic clr_err,
   input  logic en_wr,
   input  logic en_val,
   output logic pend,
   output logic errf,
   output logic en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         errf <= 1'b0;
         en   <= 1'b0;
      end else begin
         if (done || err)
            pend <= 1'b1;
         else if (st_wr && clr_pend)
            pend <= 1'b0;

         if (err)
            errf <= 1'b1;
         else if (st_wr && (clr_pend || clr_err))
            errf <= 1'b0;

         if (en_wr)
            en <= en_val;
      end
   end

   a_r7_err_needs_pend : assert property (@(posedge clk) disable iff (!rst_n)
      errf |-> pend);

   a_r7_pulse_sets : assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> pend);

   a_r9_set_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && clr_pend && err) |=> (pend && errf));

   a_r8_clear_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && clr_pend && !done && !err) |=> (!pend && !errf));
endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 12
)(
   input  logic [2:0]          word_sel,
   input  logic [2*NUM_CH-1:0] mode,
   input  logic [NUM_CH-1:0]   dir,
   input  logic [NUM_CH-1:0]   en,
   input  logic [NUM_CH-1:0]   pend,
   input  logic [NUM_CH-1:0]   errf,
   input  logic [2*NUM_CH-1:0] state,
   output logic [REG_W-1:0]    rdata
);
   logic [REG_W-1:0] p_ctl_lo [NUM_CH];
   logic [REG_W-1:0] p_ctl_hi [NUM_CH];
   logic [REG_W-1:0] p_en     [NUM_CH];
   logic [REG_W-1:0] p_st_lo  [NUM_CH];
   logic [REG_W-1:0] p_st_hi  [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_part
      localparam bit HI   = (c >= GROUP_SZ);
      localparam int SLOT = HI ? c - GROUP_SZ : c;
      localparam int ENB  = HI ? c + EN_HI_OFS : c;
      logic [REG_W-1:0] nib_w;
      logic [REG_W-1:0] st_w;
      assign nib_w = {{(REG_W-3){1'b0}}, dir[c], mode[2*c +: 2]} << (NIB_W*SLOT);
      assign st_w  = ({{(REG_W-1){1'b0}}, pend[c]} << SLOT)
                   | ({{(REG_W-1){1'b0}}, errf[c]} << (SLOT + ERR_BASE))
                   | ({{(REG_W-2){1'b0}}, state[2*c +: 2]} << (ST_BASE + 2*SLOT));
      assign p_ctl_lo[c] = HI ? '0 : nib_w;
      assign p_ctl_hi[c] = HI ? nib_w : '0;
      assign p_st_lo[c]  = HI ? '0 : st_w;
      assign p_st_hi[c]  = HI ? st_w : '0;
      assign p_en[c]     = {{(REG_W-1){1'b0}}, en[c]} << ENB;
   end

   always_comb begin
      logic [REG_W-1:0] w_cl, w_ch, w_en, w_sl, w_sh;
      w_cl = '0; w_ch = '0; w_en = '0; w_sl = '0; w_sh = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         w_cl |= p_ctl_lo[c];
         w_ch |= p_ctl_hi[c];
         w_en |= p_en[c];
         w_sl |= p_st_lo[c];
         w_sh |= p_st_hi[c];
      end
      case (word_sel)
         W_CTL_LO: rdata = w_cl;
         W_CTL_HI: rdata = w_ch;
         W_ENABLE: rdata = w_en;
         W_STS_LO: rdata = w_sl;
         W_STS_HI: rdata = w_sh;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 12
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [2:0]          reg_word,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic [2*NUM_CH-1:0] ch_mode,
   output logic [NUM_CH-1:0]   ch_dir,
   output logic [NUM_CH-1:0]   ch_start,
   output logic [NUM_CH-1:0]   ch_stop,
   input  logic [2*NUM_CH-1:0] ch_state,
   input  logic [NUM_CH-1:0]   ch_done,
   input  logic [NUM_CH-1:0]   ch_err,
   output logic                irq
);
   if (!(NUM_CH == 4 || NUM_CH == 8 || NUM_CH == 12)) begin : g_bad_num_ch
      $error("dmareg_bank: NUM_CH must be 4, 8 or 12 (R11)");
   end

   logic [NUM_CH-1:0] pend_v, errf_v, en_v;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam bit HI   = (c >= GROUP_SZ);
      localparam int SLOT = HI ? c - GROUP_SZ : c;
      localparam int ENB  = HI ? c + EN_HI_OFS : c;
      localparam logic [2:0] CTL_W = HI ? W_CTL_HI : W_CTL_LO;
      localparam logic [2:0] STS_W = HI ? W_STS_HI : W_STS_LO;

      dmareg_chan_ctl u_ctl (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (reg_wr && (reg_word == CTL_W)),
         .wr_nib    (reg_wdata[NIB_W*SLOT +: NIB_W]),
         .mode      (ch_mode[2*c +: 2]),
         .dir       (ch_dir[c]),
         .start_stb (ch_start[c]),
         .stop_stb  (ch_stop[c])
      );

      dmareg_chan_stat u_stat (
         .clk      (clk),
         .rst_n    (rst_n),
         .done     (ch_done[c]),
         .err      (ch_err[c]),
         .st_wr    (reg_wr && (reg_word == STS_W)),
         .clr_pend (reg_wdata[SLOT]),
         .clr_err  (reg_wdata[SLOT + ERR_BASE]),
         .en_wr    (reg_wr && (reg_word == W_ENABLE)),
         .en_val   (reg_wdata[ENB]),
         .pend     (pend_v[c]),
         .errf     (errf_v[c]),
         .en       (en_v[c])
      );
   end

   dmareg_rdmux #(.NUM_CH(NUM_CH)) u_rd (
      .word_sel (reg_word),
      .mode     (ch_mode),
      .dir      (ch_dir),
      .en       (en_v),
      .pend     (pend_v),
      .errf     (errf_v),
      .state    (ch_state),
      .rdata    (reg_rdata)
   );

   assign irq = |(pend_v & en_v);

   a_r1_reserved_no_effect : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_word == W_CTL_RS || reg_word == W_STS_RS))
         |=> ($stable(ch_mode) && $stable(ch_dir)));

   a_r1_reserved_no_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_word == W_CTL_RS) |-> (ch_start == '0 && ch_stop == '0));

   a_r10_enabled_pulse_irq : assert property (@(posedge clk) disable iff (!rst_n)
      (((ch_done | ch_err) & en_v) != '0 && !(reg_wr && reg_word == W_ENABLE)) |=> irq);
endmodule

// File: tb/dmareg_bank_tb.sv
module dmareg_bank_tb;
   localparam int NCH = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_word = 3'd0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [2*NCH-1:0]  ch_mode;
   logic [NCH-1:0]    ch_dir, ch_start, ch_stop;
   logic [2*NCH-1:0]  ch_state = '0;
   logic [NCH-1:0]    ch_done = '0, ch_err = '0;
   logic              irq;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [31:0] exp_q [$];
   logic [2:0]  word_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   dmareg_bank #(.NUM_CH(NCH)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_mode(ch_mode),
      .ch_dir(ch_dir), .ch_start(ch_start), .ch_stop(ch_stop),
      .ch_state(ch_state), .ch_done(ch_done), .ch_err(ch_err), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // monitor: compares queued read expectations a quarter period after the driver's edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            logic [2:0]  w;
            string       t;
            e = exp_q.pop_front();
            w = word_q.pop_front();
            t = tag_q.pop_front();
            chk($sformatf("%s word%0d", t, w), reg_rdata, e);
         end
      end
   end

   task automatic rd(input logic [2:0] w, input logic [31:0] e, input string t);
      @(negedge clk);
      reg_wr   = 1'b0;
      reg_word = w;
      exp_q.push_back(e);
      word_q.push_back(w);
      tag_q.push_back(t);
   endtask

   task automatic wr(input logic [2:0] w, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_word = w; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic wr_ctl(input logic [2:0] w, input logic [31:0] d,
                         input logic [NCH-1:0] es, input logic [NCH-1:0] ep, input string t);
      @(negedge clk);
      reg_wr = 1'b1; reg_word = w; reg_wdata = d;
      #2;
      chk({t, " start"}, 32'(ch_start), 32'(es));
      chk({t, " stop"},  32'(ch_stop),  32'(ep));
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] e);
      @(negedge clk);
      ch_done = d; ch_err = e;
      @(negedge clk);
      ch_done = '0; ch_err = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R1, R2, R5, R6, R10)
      rd(3'd0, 32'h0, "R2 reset ctl lo");
      rd(3'd3, 32'h0, "R2 reset ctl hi");
      rd(3'd2, 32'h0, "R5 reset enable");
      rd(3'd4, 32'h0, "R6 reset sts lo");
      @(negedge clk);
      chk("R10 reset irq", 32'(irq), 32'h0);
      chk("R2 reset mode", 32'(ch_mode), 32'h0);

      // R4: start for nonzero mode, stop for zero mode, same cycle
      wr_ctl(3'd0, 32'h0000_0062, 12'h003, 12'h0FC, "R4 ctl lo write");
      rd(3'd0, 32'h0000_0062, "R2 ctl lo readback");
      // R3: keep code leaves other nibbles alone
      wr_ctl(3'd0, 32'h3333_3335, 12'h001, 12'h000, "R3 keep code");
      rd(3'd0, 32'h0000_0065, "R3 keep readback");
      // R2/R11: high group, upper nibbles without channels ignored
      wr_ctl(3'd3, 32'hFFFF_3251, 12'h700, 12'h000, "R2 ctl hi write");
      rd(3'd3, 32'h0000_0251, "R11 ctl hi readback");
      @(negedge clk);
      chk("R2 ch0 mode", 32'(ch_mode[1:0]), 32'd1);
      chk("R2 ch0 dir", 32'(ch_dir[0]), 32'd1);
      chk("R2 ch1 mode", 32'(ch_mode[3:2]), 32'd2);
      chk("R2 ch8 mode", 32'(ch_mode[17:16]), 32'd1);
      chk("R2 ch9 dir", 32'(ch_dir[9]), 32'd1);

      // R5 enable placement
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, 32'h000F_00FF, "R5 enable all");
      wr(3'd2, 32'h0004_0001);
      rd(3'd2, 32'h0004_0001, "R5 enable ch0 ch10");

      // R6 state fields
      @(negedge clk);
      ch_state = '0;
      ch_state[1:0] = 2'd1; ch_state[3:2] = 2'd2; ch_state[5:4] = 2'd3;
      ch_state[17:16] = 2'd3; ch_state[23:22] = 2'd2;
      rd(3'd4, 32'h0039_0000, "R6 state lo");
      rd(3'd6, 32'h0083_0000, "R6 state hi");

      // R7 / R10
      pulse(12'h002, 12'h000);
      chk("R10 disabled channel no irq", 32'(irq), 32'h0);
      rd(3'd4, 32'h0039_0002, "R7 done ch1");
      pulse(12'h000, 12'h001);
      chk("R10 enabled ch0 irq", 32'(irq), 32'h1);
      rd(3'd4, 32'h0039_0103, "R7 err ch0");
      pulse(12'h400, 12'h000);
      rd(3'd6, 32'h0083_0004, "R7 done ch10");

      // R8 write-one-to-clear
      wr(3'd4, 32'h0000_0002);
      rd(3'd4, 32'h0039_0101, "R8 clear ch1");
      wr(3'd4, 32'hFFFF_0001);
      rd(3'd4, 32'h0039_0000, "R8 clear ch0 pend+err, state kept");
      @(negedge clk);
      chk("R10 ch10 still irq", 32'(irq), 32'h1);
      wr(3'd6, 32'h0000_0004);
      rd(3'd6, 32'h0083_0000, "R8 clear ch10");
      @(negedge clk);
      chk("R10 irq drops", 32'(irq), 32'h0);

      // R9 set beats clear
      @(negedge clk);
      reg_wr = 1'b1; reg_word = 3'd4; reg_wdata = 32'h8; ch_done = 12'h008;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; ch_done = '0;
      rd(3'd4, 32'h0039_0008, "R9 set wins");
      wr(3'd4, 32'h0000_0008);

      // R8 error-only clear
      pulse(12'h000, 12'h010);
      rd(3'd4, 32'h0039_1010, "R7 err ch4");
      wr(3'd4, 32'h0000_1000);
      rd(3'd4, 32'h0039_0010, "R8 err only clear");
      wr(3'd4, 32'h0000_0010);

      // R1 reserved words
      wr_ctl(3'd1, 32'hFFFF_FFFF, 12'h000, 12'h000, "R1 ctl rsv write");
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd1, 32'h0, "R1 ctl rsv read");
      rd(3'd5, 32'h0, "R1 sts rsv read");
      rd(3'd7, 32'h0, "R1 idx7 read");
      rd(3'd0, 32'h0000_0065, "R1 ctl lo unchanged");
      rd(3'd4, 32'h0039_0000, "R1 sts lo unchanged");

      repeat (3) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule